// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This block collects one fast interrupt request and a set of normal interrupt requests (31 by default) and drives two outputs to a processor: a fast interrupt line and a normal interrupt line. The fast path is a synchronised level that is gated by its own enable bit. Each normal source has an enable bit and a programmable 3-bit priority level. The level arbiter picks the pending, enabled source with the highest level. When two such sources share a level, the lower source number wins.

The controller keeps a current service level and a small stack of earlier levels. A normal request can reach the processor only while its level is strictly above the current level. Software takes an interrupt by reading the vector register. The read returns the winning source number, clears that source's pending bit, saves the current level on the stack and raises the current level to the winner's level. A write to the end-of-service register restores the saved level. Nested service therefore works: a higher level can preempt a running handler, and an equal or lower level cannot.

All register access goes through a plain single-cycle bus with no back-pressure. `rdata_o` is combinational while `rd_en_i` is high. Side effects take place at the clock edge that ends that cycle. `rd_en_i` and `wr_en_i` are never high together.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `fiq_o` equals the fast request delayed by two clock edges, ANDed with the fast enable (bit 0 of address 1). With the enable at 0, `fiq_o` stays low.
- R2: A rising edge on a normal request sets that source's pending bit. The bit stays set after the request falls. Pending bits read at address 5, with bit n for source n.
- R3: A pending source competes for service only if its enable bit (address 0, bit n) is 1 and its level is nonzero. Level 0 disables the source.
- R4: Among competing sources the highest level wins. On equal levels the lowest source number wins.
- R5: `irq_o` is high exactly when a winner exists and its level is strictly greater than the current level.
- R6: A read of address 2 while `irq_o` is high returns the source number in bits [4:0], 1 in bit 8 and the winner's level in bits [18:16]. At that edge the read clears the source's pending bit, pushes the current level and makes the winner's level current.
- R7: A read of address 2 while `irq_o` is low returns 0 and changes no state.
- R8: Any write to address 3 pops the stack and restores the saved level. With the stack empty the write has no effect.
- R9: The status register (address 4) holds the current level in bits [2:0] and the nesting depth in bits [10:8]. Because each push raises the level strictly, the depth never exceeds 7.
- R10: After reset, every register, pending bit, level and output is 0.
- R11: Levels are read and written at addresses 8 upward. Address 8+g holds sources 8g to 8g+7. Source 8g+j sits in bits [4j+2:4j]. Bits for missing sources read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_req_i | input | 1 | Fast interrupt request (level) |
| irq_req_i | input | NSRC | Normal interrupt requests, latched on their rising edge |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while rd_en_i is high |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
The assertions assume that reads and writes are never issued in the same cycle. They also assume that every request level is held for at least two cycles, so the synchroniser sees each edge. The bench drives one bus operation at a time, on the falling edge, and holds every request high and then low for four cycles. Several programmed level maps, enable masks and request patterns are swept. After each pattern the pending set is drained through nested vector reads and end-of-service writes, which deepen and unwind the level stack.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t REG_SRC_EN  = 4'd0;
  localparam addr_t REG_FAST_EN = 4'd1;
  localparam addr_t REG_VECTOR  = 4'd2;
  localparam addr_t REG_EOS     = 4'd3;
  localparam addr_t REG_STATUS  = 4'd4;
  localparam addr_t REG_PEND    = 4'd5;
  localparam addr_t REG_LVL0    = 4'd8;

  localparam int VEC_VALID_BIT  = 8;
  localparam int VEC_LVL_LSB    = 16;
  localparam int STAT_DEPTH_LSB = 8;
  localparam int NIB_W          = 4;
  localparam int SRC_PER_GRP    = 8;
endpackage

// File: rtl/pic_sync2.sv
module pic_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC  = 31,
  parameter int LVL_W = 3,
  parameter int ID_W  = 5
) (
  input  logic [NSRC-1:0]       cand_i,
  input  logic [NSRC*LVL_W-1:0] lvl_i,
  output logic                  win_valid_o,
  output logic [ID_W-1:0]       win_id_o,
  output logic [LVL_W-1:0]      win_lvl_o
);
  // Strict greater-than on an ascending scan keeps the lowest index on ties.
  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    win_lvl_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && (lvl_i[i*LVL_W +: LVL_W] > win_lvl_o)) begin
        win_valid_o = 1'b1;
        win_id_o    = ID_W'(i);
        win_lvl_o   = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack #(
  parameter int LVL_W   = 3,
  parameter int DEPTH   = 7,
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [LVL_W-1:0]   push_lvl_i,
  output logic [LVL_W-1:0]   cur_o,
  output logic [DEPTH_W-1:0] depth_o
);
  localparam int SLOTS = 1 << DEPTH_W;

  logic [LVL_W-1:0] saved [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_o   <= '0;
      depth_o <= '0;
      for (int k = 0; k < SLOTS; k++) saved[k] <= '0;
    end else if (push_i) begin
      saved[depth_o] <= cur_o;
      cur_o          <= push_lvl_i;
      depth_o        <= depth_o + 1'b1;
    end else if (pop_i) begin
      cur_o   <= saved[depth_o - 1'b1];
      depth_o <= depth_o - 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NSRC      = 31,
  parameter int LVL_W     = 3,
  parameter int STK_DEPTH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fiq_req_i,
  input  logic [NSRC-1:0]   irq_req_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int ID_W    = $clog2(NSRC);
  localparam int DEPTH_W = $clog2(STK_DEPTH + 1);

  logic                  fast_sync, fast_en_q;
  logic [NSRC-1:0]       req_sync, req_prev, req_rise;
  logic [NSRC-1:0]       pend_q, src_en_q, lvl_nz, cand, clr_mask;
  logic [LVL_W-1:0]      lvl_q [NSRC];
  logic [NSRC*LVL_W-1:0] lvl_flat;
  logic                  win_valid;
  logic [ID_W-1:0]       win_id;
  logic [LVL_W-1:0]      win_lvl, cur_lvl;
  logic [DEPTH_W-1:0]    depth;
  logic                  above, vec_take, eos_pop;
  logic [DATA_W-1:0]     rd_mux;
  logic                  unused_wdata;

  assign unused_wdata = ^wdata_i;

  pic_sync2 #(.W(1)) u_fast_sync (
    .clk(clk), .rst_n(rst_n), .d_i(fiq_req_i), .q_o(fast_sync)
  );

  pic_sync2 #(.W(NSRC)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_req_i), .q_o(req_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev  <= '0;
      src_en_q  <= '0;
      fast_en_q <= 1'b0;
      pend_q    <= '0;
    end else begin
      req_prev <= req_sync;
      pend_q   <= (pend_q & ~clr_mask) | req_rise;
      if (wr_en_i && addr_i == REG_SRC_EN)  src_en_q  <= wdata_i[NSRC-1:0];
      if (wr_en_i && addr_i == REG_FAST_EN) fast_en_q <= wdata_i[0];
    end
  end

  assign req_rise = req_sync & ~req_prev;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam addr_t GRP_ADDR = addr_t'(REG_LVL0 + i / SRC_PER_GRP);
    localparam int    NIB_LSB  = (i % SRC_PER_GRP) * NIB_W;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= '0;
      else if (wr_en_i && addr_i == GRP_ADDR) lvl_q[i] <= wdata_i[NIB_LSB +: LVL_W];
    end

    assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q[i];
    assign lvl_nz[i] = |lvl_q[i];
  end

  assign cand = pend_q & src_en_q & lvl_nz;

  pic_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
    .cand_i(cand), .lvl_i(lvl_flat),
    .win_valid_o(win_valid), .win_id_o(win_id), .win_lvl_o(win_lvl)
  );

  assign above    = win_valid && (win_lvl > cur_lvl);
  assign vec_take = rd_en_i && addr_i == REG_VECTOR && above;
  assign eos_pop  = wr_en_i && addr_i == REG_EOS && !vec_take && (depth != '0);
  assign clr_mask = vec_take ? (NSRC'(1) << win_id) : '0;

  pic_level_stack #(.LVL_W(LVL_W), .DEPTH(STK_DEPTH), .DEPTH_W(DEPTH_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(vec_take), .pop_i(eos_pop),
    .push_lvl_i(win_lvl), .cur_o(cur_lvl), .depth_o(depth)
  );

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      REG_SRC_EN:  rd_mux[NSRC-1:0] = src_en_q;
      REG_FAST_EN: rd_mux[0] = fast_en_q;
      REG_VECTOR: begin
        if (above) begin
          rd_mux[ID_W-1:0]                = win_id;
          rd_mux[VEC_VALID_BIT]           = 1'b1;
          rd_mux[VEC_LVL_LSB +: LVL_W]    = win_lvl;
        end
      end
      REG_STATUS: begin
        rd_mux[LVL_W-1:0]                 = cur_lvl;
        rd_mux[STAT_DEPTH_LSB +: DEPTH_W] = depth;
      end
      REG_PEND:    rd_mux[NSRC-1:0] = pend_q;
      default: begin
        for (int i = 0; i < NSRC; i++) begin
          if (addr_i == addr_t'(REG_LVL0 + i / SRC_PER_GRP))
            rd_mux[(i % SRC_PER_GRP)*NIB_W +: LVL_W] = lvl_q[i];
        end
      end
    endcase
  end

  assign rdata_o = rd_en_i ? rd_mux : '0;
  assign fiq_o   = fast_sync & fast_en_q;
  assign irq_o   = above;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC      = 31,
  parameter int LVL_W     = 3,
  parameter int STK_DEPTH = 7,
  parameter int DEPTH_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fiq_o,
  input logic               irq_o,
  input logic               fast_en_q,
  input logic               vec_take,
  input logic               eos_pop,
  input logic [LVL_W-1:0]   win_lvl,
  input logic [LVL_W-1:0]   cur_lvl,
  input logic [DEPTH_W-1:0] depth,
  input logic [NSRC-1:0]    cand
);
  AST_FAST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> fast_en_q); // R1

  AST_IRQ_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($countones(cand) != 0)); // R3

  AST_TAKE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> (cur_lvl == $past(win_lvl))); // R6

  AST_POP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    eos_pop |=> (cur_lvl < $past(cur_lvl))); // R8

  AST_LVL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_take && !eos_pop) |=> $stable(cur_lvl)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |-> (32'(depth) < STK_DEPTH)); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NSRC(NSRC), .LVL_W(LVL_W), .STK_DEPTH(STK_DEPTH), .DEPTH_W(DEPTH_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fiq_o(fiq_o), .irq_o(irq_o),
  .fast_en_q(fast_en_q), .vec_take(vec_take), .eos_pop(eos_pop),
  .win_lvl(win_lvl), .cur_lvl(cur_lvl), .depth(depth), .cand(cand)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NSRC = 31;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fiq_req = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            fiq_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [NSRC-1:0] m_pend = '0, m_en = '0;
  logic [2:0]      m_lvl [NSRC];
  logic [2:0]      m_stk [8];
  logic [2:0]      m_cur = '0;
  int              m_depth = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fiq_req_i(fiq_req), .irq_req_i(irq_req),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .fiq_o(fiq_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic [31:0] exp_vec();
    int best = -1;
    logic [2:0] bl = '0;
    for (int i = 0; i < NSRC; i++)
      if (m_pend[i] && m_en[i] && m_lvl[i] != 0 && m_lvl[i] > bl) begin
        best = i; bl = m_lvl[i];
      end
    if (best >= 0 && bl > m_cur) return {13'b0, bl, 7'b0, 1'b1, 3'b0, 5'(best)};
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_status();
    return (32'(m_depth) << 8) | 32'(m_cur);
  endfunction

  function automatic logic [31:0] pack_grp(input int g);
    logic [31:0] d = '0;
    for (int j = 0; j < 8; j++)
      if (g*8 + j < NSRC) d[j*4 +: 3] = m_lvl[g*8 + j];
    return d;
  endfunction

  task automatic load_levels();
    for (int g = 0; g < 4; g++) bus_write(4'(8 + g), pack_grp(g));
  endtask

  task automatic pulse(input logic [NSRC-1:0] pat);
    @(negedge clk); irq_req = pat;
    repeat (4) @(negedge clk);
    irq_req = '0;
    repeat (4) @(negedge clk);
    m_pend |= pat;
  endtask

  task automatic take_vector(output bit valid);
    logic [31:0] e, d;
    e = exp_vec();
    chk("R5 irq_o", 32'(irq_o), 32'(e[8]));
    bus_read(4'd2, d);
    chk(e[8] ? "R4/R6 vector" : "R7 empty vector", d, e);
    valid = e[8];
    if (valid) begin
      m_pend[e[4:0]] = 1'b0;
      m_stk[m_depth] = m_cur;
      m_depth++;
      m_cur = e[18:16];
    end
    bus_read(4'd4, d);
    chk("R9 status", d, exp_status());
  endtask

  task automatic end_service();
    logic [31:0] d;
    bus_write(4'd3, 32'h0);
    if (m_depth > 0) begin
      m_depth--;
      m_cur = m_stk[m_depth];
    end
    bus_read(4'd4, d);
    chk("R8 status after pop", d, exp_status());
  endtask

  task automatic drain();
    bit v;
    for (int guard = 0; guard < 200; guard++) begin
      take_vector(v);
      if (!v) begin
        if (m_depth == 0) break;
        while (m_depth > 0) end_service();
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit v;
    for (int i = 0; i < NSRC; i++) m_lvl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    chk("R10 irq_o", 32'(irq_o), 0);
    chk("R10 fiq_o", 32'(fiq_o), 0);
    for (int a = 0; a < 12; a++) begin
      if (a == 3 || a == 6 || a == 7) continue;
      bus_read(4'(a), d);
      chk("R10 register", d, 0);
    end

    // R1: fast path gating and two-edge latency
    fiq_req = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 fiq disabled", 32'(fiq_o), 0);
    bus_write(4'd1, 32'h1);
    chk("R1 fiq enabled", 32'(fiq_o), 1);
    fiq_req = 1'b0;
    @(negedge clk);
    chk("R1 fiq after one edge", 32'(fiq_o), 1);
    @(negedge clk);
    chk("R1 fiq after two edges", 32'(fiq_o), 0);

    // R11: level register layout and readback
    for (int i = 0; i < NSRC; i++) m_lvl[i] = 3'((i * 5 + 2) % 8);
    load_levels();
    for (int g = 0; g < 4; g++) begin
      bus_read(4'(8 + g), d);
      chk("R11 level readback", d, pack_grp(g));
    end
    bus_write(4'd11, 32'hFFFF_FFFF);
    m_lvl[24] = 3'd7; m_lvl[25] = 3'd7; m_lvl[26] = 3'd7; m_lvl[27] = 3'd7;
    m_lvl[28] = 3'd7; m_lvl[29] = 3'd7; m_lvl[30] = 3'd7;
    bus_read(4'd11, d);
    chk("R11 missing source bits", d, 32'h0777_7777);

    // R2..R7: sweep of level maps, enable masks and request patterns
    for (int p = 0; p < 14; p++) begin
      logic [NSRC-1:0] pat;
      for (int i = 0; i < NSRC; i++) m_lvl[i] = 3'((i * 3 + p * 5) % 8);
      if (p == 5) for (int i = 0; i < NSRC; i++) m_lvl[i] = 3'd4;
      load_levels();
      m_en = {NSRC{1'b1}};
      m_en[(p * 7) % NSRC] = 1'b0;
      if (p == 9) m_en = '0;
      bus_write(4'd0, 32'(m_en));
      bus_read(4'd0, d);
      chk("R3 enable readback", d, 32'(m_en));
      pat = NSRC'((32'h9E37_79B1 * (p + 1)) ^ (p << 3));
      pulse(pat);
      bus_read(4'd5, d);
      chk("R2 pending latched", d, 32'(m_pend));
      drain();
    end

    // R9/R5/R8: deepest nesting, blocking, pop on empty stack
    for (int i = 0; i < NSRC; i++) m_lvl[i] = (i < 7) ? 3'(i + 1) : 3'd0;
    load_levels();
    m_en = {NSRC{1'b1}};
    bus_write(4'd0, 32'(m_en));
    drain();
    for (int k = 0; k < 7; k++) begin
      pulse(NSRC'(1) << k);
      take_vector(v);
      chk("R9 nested take", 32'(v), 1);
    end
    chk("R9 depth seven", 32'(m_depth), 7);
    pulse(NSRC'(1));
    chk("R5 blocked at or below level", 32'(irq_o), 0);
    take_vector(v);
    while (m_depth > 0) end_service();
    chk("R5 unblocked after unwind", 32'(irq_o), 1);
    end_service();
    chk("R8 pop on empty keeps irq", 32'(irq_o), 1);
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule